// File: doc/BRIEF.md
# Conversion Trigger and Sample Buffer Controller

This block sits between a register bus and a 12-bit analog-to-digital converter. Software sets one of three trigger sources: a bus write, an on-chip pacer, or the rising edge of an external pin. An optional external gate can hold off the pacer and external triggers. The block issues a one-cycle conversion start pulse and refuses further triggers until the converter signals done. Each result it receives is stored in a 4096-entry sample buffer that software drains through a data read port.

The pacer is a chain of two 16-bit down counters. The first counter advances on a 10 MHz timebase enable, and the second advances on the first counter's terminal count, so the trigger period is the product of the two divisors. An interrupt can be raised on every finished conversion or when the buffer reaches half full. A status word echoes the control bits and reports the buffer flags, the pending interrupt and a sticky overrun flag. Separate bus writes clear the pending interrupt and flush the buffer.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset the control word is zero, the buffer is empty (empty=1, half=0, full=0), and irq and conv_start are low.
- R2: A write to address 1 loads the control word: bit0 software trigger enable, bit1 pacer enable, bit2 external trigger enable, bit3 gate enable, bit4 interrupt enable, bit5 interrupt source (0 = every conversion, 1 = half full). If the write sets more than one of bits 0 to 2, all three trigger enables are cleared. Status bits 5:0, read from address 1, echo the control word.
- R3: With the software enable set, a write to address 0 makes conv_start high for exactly the one cycle after the write edge. With the software enable clear, such a write starts nothing.
- R4: With the external enable set, a low-to-high edge on ext_trig passes through a two-flop synchronizer and an edge detector, and conv_start rises on the third clock edge after the pin changes. With the gate enable set, pacer and external triggers are accepted only while the synchronized ext_gate is high.
- R5: With the pacer enabled, divisor A (address 4) and divisor B (address 5) give one trigger every A*B cycles in which tick is high. The counters reload while the pacer is disabled.
- R6: Once conv_start has fired, any trigger is dropped until conv_done is seen.
- R7: Each conv_done pushes conv_data into the buffer. A read of address 0 pops the oldest sample, and reg_rdata then shows {4'b0, sample} in the following cycle. Samples come out in arrival order.
- R8: The flags are fifo_empty (count 0), fifo_half (count at least 2048) and fifo_full (count 4096). A sample that arrives while the buffer is full is discarded and sets the sticky overrun flag, status bit 12. Status bits 8, 9, 10 and 11 are empty, half, full and interrupt pending.
- R9: With the interrupt enabled, irq goes high after a conv_done when the source is 0, or in the cycle after the buffer becomes half full when the source is 1. With the interrupt disabled, irq stays low.
- R10: A write to address 2 clears irq. A write to address 3 empties the buffer and clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| ext_gate | input | 1 | External gate pin, asynchronous |
| tick | input | 1 | 10 MHz timebase enable for the pacer |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result |
| conv_start | output | 1 | One-cycle conversion start pulse |
| irq | output | 1 | Interrupt pending |
| fifo_empty | output | 1 | Buffer empty |
| fifo_half | output | 1 | Buffer at least half full |
| fifo_full | output | 1 | Buffer full |

## Verification
On every cycle the assertions check these rules: at most one trigger enable is active, no start is issued while a conversion is pending, the buffer is never both full and empty, a push into a full buffer leaves it full with the overrun flag set, the clear writes take effect, and the pacer stays silent while it is disabled. Only the bench scenarios can show sample ordering and data format, the exact trigger latencies, the pacer period as the product of the divisors, the gate hold-off, and the two interrupt sources. The 2048 and 4096 flag thresholds also need the bench, which fills and drains the whole buffer.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = 16;

  localparam logic [ADDR_W-1:0] ADR_DATA     = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CLR_IRQ  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR_FIFO = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DIV_A    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_DIV_B    = 3'd5;

  localparam int CB_SW    = 0;
  localparam int CB_PACER = 1;
  localparam int CB_EXT   = 2;
  localparam int CB_GATE  = 3;
  localparam int CB_IRQEN = 4;
  localparam int CB_IRQSRC = 5;
  localparam int CTRL_W   = 6;

  localparam int SB_EMPTY = 8;
  localparam int SB_HALF  = 9;
  localparam int SB_FULL  = 10;
  localparam int SB_IRQ   = 11;
  localparam int SB_OVR   = 12;
endpackage

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run,
  input  logic                          tick,
  input  logic [STAGES-1:0][CNT_W-1:0]  divs,
  output logic                          fire
);
  logic [STAGES:0] step;
  assign step[0] = run & tick;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [CNT_W-1:0] cnt;
    assign step[g+1] = step[g] & (cnt == CNT_W'(1));
    always_ff @(posedge clk) begin
      if (rst || !run) begin
        cnt <= divs[g];
      end else if (step[g]) begin
        if (cnt == CNT_W'(1)) cnt <= divs[g];
        else                  cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) fire <= 1'b0;
    else             fire <= step[STAGES];
  end

  AST_PACER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !fire); // R5
endmodule

// File: rtl/acq_trig_sel.sv
module acq_trig_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_en,
  input  logic pacer_en,
  input  logic ext_en,
  input  logic gate_en,
  input  logic sw_hit,
  input  logic pacer_fire,
  input  logic ext_pin,
  input  logic gate_pin,
  input  logic conv_done,
  output logic conv_start,
  output logic busy
);
  logic [SYNC_STAGES-1:0] trig_sync, gate_sync;
  logic trig_prev, ext_rise, gate_open, req, fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_sync <= '0;
      gate_sync <= '0;
      trig_prev <= 1'b0;
    end else begin
      trig_sync <= {trig_sync[SYNC_STAGES-2:0], ext_pin};
      gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_pin};
      trig_prev <= trig_sync[SYNC_STAGES-1];
    end
  end

  assign ext_rise  = trig_sync[SYNC_STAGES-1] & ~trig_prev;
  assign gate_open = ~gate_en | gate_sync[SYNC_STAGES-1];
  assign req  = (sw_en & sw_hit)
              | (pacer_en & pacer_fire & gate_open)
              | (ext_en & ext_rise & gate_open);
  assign fire = req & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      conv_start <= fire;
      if (fire)           busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
    end
  end

  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> !conv_start); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R3
endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              half,
  output logic              full,
  output logic              overrun
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign half    = (count >= CNT_W'(DEPTH / 2));
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wptr <= wptr + PTR_W'(1);
      if (do_pop)  rptr <= rptr + PTR_W'(1);
      if (do_push && !do_pop)      count <= count + CNT_W'(1);
      else if (do_pop && !do_push) count <= count - CNT_W'(1);
      if (push && full) overrun <= 1'b1;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (full && overrun)); // R8
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4096,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              ext_trig,
  input  logic              ext_gate,
  input  logic              tick,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_start,
  output logic              irq,
  output logic              fifo_empty,
  output logic              fifo_half,
  output logic              fifo_full
);
  localparam int PAD_W = BUS_W - DATA_W;

  logic [CTRL_W-1:0]     ctrl;
  logic [1:0][DIV_W-1:0] divs;
  logic [DATA_W-1:0]     fifo_q;
  logic [BUS_W-1:0]      status_q;
  logic sel_data_q, half_q, overrun, busy, pacer_fire;
  logic wr_data, wr_ctrl, clr_irq, clr_fifo, rd_data, multi_trig, irq_set;

  assign wr_data  = reg_wr && reg_addr == ADR_DATA;
  assign wr_ctrl  = reg_wr && reg_addr == ADR_CTRL;
  assign clr_irq  = reg_wr && reg_addr == ADR_CLR_IRQ;
  assign clr_fifo = reg_wr && reg_addr == ADR_CLR_FIFO;
  assign rd_data  = reg_rd && reg_addr == ADR_DATA;
  assign multi_trig = (reg_wdata[0] & reg_wdata[1]) | (reg_wdata[0] & reg_wdata[2])
                    | (reg_wdata[1] & reg_wdata[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      divs <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADR_CTRL)
        ctrl <= {reg_wdata[CTRL_W-1:3], multi_trig ? 3'b000 : reg_wdata[2:0]};
      if (reg_addr == ADR_DIV_A) divs[0] <= reg_wdata[DIV_W-1:0];
      if (reg_addr == ADR_DIV_B) divs[1] <= reg_wdata[DIV_W-1:0];
    end
  end

  acq_pacer #(.CNT_W(DIV_W), .STAGES(2)) i_pacer (
    .clk(clk), .rst(rst), .run(ctrl[CB_PACER]), .tick(tick),
    .divs(divs), .fire(pacer_fire)
  );

  acq_trig_sel #(.SYNC_STAGES(2)) i_trig (
    .clk(clk), .rst(rst),
    .sw_en(ctrl[CB_SW]), .pacer_en(ctrl[CB_PACER]), .ext_en(ctrl[CB_EXT]),
    .gate_en(ctrl[CB_GATE]), .sw_hit(wr_data), .pacer_fire(pacer_fire),
    .ext_pin(ext_trig), .gate_pin(ext_gate), .conv_done(conv_done),
    .conv_start(conv_start), .busy(busy)
  );

  acq_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .clr(clr_fifo),
    .push(conv_done), .wdata(conv_data),
    .pop(rd_data), .rdata(fifo_q),
    .empty(fifo_empty), .half(fifo_half), .full(fifo_full), .overrun(overrun)
  );

  assign irq_set = ctrl[CB_IRQSRC] ? (fifo_half & ~half_q) : conv_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      half_q <= 1'b0;
    end else begin
      half_q <= fifo_half;
      if (clr_irq)                       irq <= 1'b0;
      else if (ctrl[CB_IRQEN] && irq_set) irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_data_q <= 1'b0;
      status_q   <= '0;
    end else if (reg_rd) begin
      sel_data_q <= rd_data;
      status_q   <= '0;
      status_q[CTRL_W-1:0] <= ctrl;
      status_q[SB_EMPTY]   <= fifo_empty;
      status_q[SB_HALF]    <= fifo_half;
      status_q[SB_FULL]    <= fifo_full;
      status_q[SB_IRQ]     <= irq;
      status_q[SB_OVR]     <= overrun;
    end
  end

  assign reg_rdata = sel_data_q ? {{PAD_W{1'b0}}, fifo_q} : status_q;

  AST_ONE_TRIG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl[2:0])); // R2
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_irq |=> !irq); // R10
  AST_FIFO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_fifo |=> (fifo_empty && !overrun)); // R10
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[CB_IRQEN] && !irq) |=> !irq); // R9
endmodule

// File: tb/test_acq_trig_ctrl.sv
module test_acq_trig_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic ext_trig = 0, ext_gate = 0, tick = 0, conv_done = 0;
  logic [11:0] conv_data = 0;
  logic conv_start, irq, fifo_empty, fifo_half, fifo_full;
  int checks = 0, fails = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  acq_trig_ctrl i_acq_trig_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .ext_gate(ext_gate), .tick(tick), .conv_done(conv_done), .conv_data(conv_data),
    .conv_start(conv_start), .irq(irq), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .fifo_full(fifo_full)
  );

  localparam logic [11:0] VEC [0:5] = '{12'h000, 12'hFFF, 12'hA5C, 12'h123, 12'h800, 12'h7FF};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [11:0] d);
    conv_done = 1; conv_data = d;
    @(negedge clk);
    conv_done = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, nstart;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 conv_start", conv_start, 0);
    check("R1 irq", irq, 0);
    check("R1 flags", {fifo_empty, fifo_half, fifo_full}, 3'b100);
    rd(3'd1, rv);
    check("R1 status", rv, 16'h0100);

    // R3 write to data with software trigger disabled
    wr(3'd0, 16'h0);
    check("R3 no start when disabled", conv_start, 0);

    // R2 multiple trigger enables cleared, gate kept
    wr(3'd1, 16'h000F);
    rd(3'd1, rv);
    check("R2 multi enable", rv[5:0], 6'h08);

    // R2/R3/R7/R9 vector table: software trigger, convert, interrupt each sample
    wr(3'd1, 16'h0011);
    rd(3'd1, rv);
    check("R2 echo", rv[5:0], 6'h11);
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, 16'h0);
      check("R3 sw start", conv_start, 1);
      @(negedge clk);
      check("R3 single pulse", conv_start, 0);
      push(VEC[i]);
      check("R9 irq every conversion", irq, 1);
      wr(3'd2, 16'h0);
      check("R10 irq cleared", irq, 0);
    end
    for (int i = 0; i < 6; i++) begin
      rd(3'd0, rv);
      check("R7 order and format", rv, {4'h0, VEC[i]});
    end
    check("R8 empty after drain", fifo_empty, 1);

    // R6 busy drop
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0);
    check("R6 first start", conv_start, 1);
    wr(3'd0, 16'h0);
    check("R6 dropped while busy", conv_start, 0);
    push(12'h055);
    wr(3'd0, 16'h0);
    check("R6 start after done", conv_start, 1);
    push(12'h056);
    wr(3'd3, 16'h0);
    check("R10 fifo cleared", fifo_empty, 1);

    // R4 external edge through synchronizer
    wr(3'd1, 16'h0004);
    ext_trig = 1;
    @(negedge clk); @(negedge clk);
    check("R4 not yet", conv_start, 0);
    @(negedge clk);
    check("R4 ext start", conv_start, 1);
    push(12'h0);
    repeat (4) @(negedge clk);
    check("R4 level no retrigger", conv_start, 0);
    ext_trig = 0;
    // R4 gate closed
    wr(3'd1, 16'h000C);
    repeat (3) @(negedge clk);
    ext_trig = 1;
    nstart = 0;
    for (int c = 0; c < 6; c++) begin @(negedge clk); if (conv_start) nstart++; end
    check("R4 gated ext", nstart, 0);
    ext_trig = 0; ext_gate = 1;
    repeat (4) @(negedge clk);
    ext_trig = 1;
    nstart = 0;
    for (int c = 0; c < 6; c++) begin @(negedge clk); if (conv_start) nstart++; end
    check("R4 gate open ext", nstart, 1);
    push(12'h0);
    ext_trig = 0; ext_gate = 0;

    // R5 pacer period A*B = 6 ticks
    wr(3'd1, 16'h0);
    wr(3'd4, 16'd2);
    wr(3'd5, 16'd3);
    tick = 1;
    wr(3'd1, 16'h0002);
    t0 = -1; t1 = -1; nstart = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      conv_done = 0;
      if (conv_start) begin
        conv_done = 1;
        if (nstart == 1) t0 = c;
        if (nstart == 2) t1 = c;
        nstart++;
      end
    end
    @(negedge clk); conv_done = 0;
    check("R5 pacer interval", t1 - t0, 6);
    // R4 gate blocks the pacer
    wr(3'd1, 16'h000A);
    nstart = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (conv_start) nstart++; end
    check("R4 gated pacer", nstart, 0);
    wr(3'd1, 16'h0);
    tick = 0;
    wr(3'd3, 16'h0);

    // R8/R9 fill: half-full interrupt, full, overrun
    wr(3'd1, 16'h0030);
    for (int i = 0; i < 2047; i++) push(i[11:0]);
    @(negedge clk);
    check("R8 below half", fifo_half, 0);
    check("R9 no half irq yet", irq, 0);
    push(12'd2047);
    check("R8 half", fifo_half, 1);
    @(negedge clk);
    check("R9 half irq", irq, 1);
    for (int i = 2048; i < 4096; i++) push(i[11:0]);
    check("R8 full", fifo_full, 1);
    rd(3'd1, rv);
    check("R8 status flags", rv[12:8], 5'b01110);
    push(12'hEEE);
    rd(3'd1, rv);
    check("R8 overrun sticky", rv[12], 1);
    check("R8 still full", fifo_full, 1);
    for (int i = 0; i < 4096; i++) begin
      rd(3'd0, rv);
      if (i == 0 || i == 4095) check("R7 drain order", rv, {4'h0, i[11:0]});
    end
    check("R8 empty after full drain", fifo_empty, 1);
    wr(3'd3, 16'h0);
    rd(3'd1, rv);
    check("R10 overrun cleared", rv[12], 0);
    wr(3'd2, 16'h0);

    // R9 interrupt disabled
    wr(3'd1, 16'h0001);
    push(12'h001);
    check("R9 disabled irq", irq, 0);
    finish_run();
  end
endmodule